// File: doc/BRIEF.md
# SONET Framing Byte Inserter

This block sits in the byte-wide transmit path of one or more STS-12 streams. It overwrites the start of every frame with the section framing pattern: twelve A1 bytes followed by twelve A2 bytes. Every other byte passes through unchanged, one register stage late. A shared position counter locates the framing bytes. A single-cycle frame-start pulse marks the first A1 byte of each frame and resynchronises the counter. Between pulses the counter walks 9 rows of 1080 bytes and wraps on its own.

For link testing, each stream can send a corrupted frame alignment word. When a stream's test enable is armed, two bytes take the shared programmable values: the last A1 byte and the first A2 byte. The other 22 framing bytes keep their normal pattern. Corruption lasts for a shared, programmed number of frames. A count of zero means it lasts until the enable is dropped. The enable is looked at only on frame-start cycles, so a burst always covers whole frames. A finished counted burst starts again only after the enable has been seen low at one frame start and high at a later one. Each stream reports a busy flag while corrupting and a one-cycle done flag when a counted burst completes.

Top module: `sfi_frame_inserter`

## Requirements
- R1: Bytes outside the framing positions, and all bytes before the first frame-start pulse after reset, appear on `dout` unchanged exactly one clock after they are presented on `din`.
- R2: Without corruption, row 0 byte positions 0 to 11 (position 0 = the frame-start cycle) are output as 0xF6 and positions 12 to 23 as 0x28.
- R3: While a stream is corrupting, only its position 11 byte is replaced by `ins_a1_val` and its position 12 byte by `ins_a2_val`. All other framing positions keep 0xF6/0x28.
- R4: With `ins_frames` = N > 0, a stream that is idle and sees its enable high at a frame start corrupts that frame and the next N-1 frames. It then stops.
- R5: With `ins_frames` = 0 at burst start, corruption continues on every frame until a frame start sees the enable low.
- R6: After a counted burst ends, holding the enable high starts no new burst. A new burst starts only at a frame start seeing the enable high after an earlier frame start saw it low. An enable already high at the first frame start after reset starts a burst.
- R7: The enable is sampled only on frame-start cycles. A change in mid-frame has no effect on that frame, and `ins_busy` changes only in the cycle after a frame start.
- R8: `ins_done` of a stream pulses high for exactly one cycle, in the cycle after the frame start that ends a counted burst. At that moment `ins_busy` falls. `ins_busy` is high exactly while a burst is in progress.
- R9: Streams are independent. The corrupt values and the frame count are shared, while each stream follows only its own enable bit.
- R10: Synchronous active-high reset clears `dout`, `ins_busy` and `ins_done` to zero, and all streams return to idle.
- R11: A frame start seeing the enable low during a counted burst ends it at once without a done pulse.
- R12: Framing is written only in row 0. Positions 0 to 23 of later rows (position 1080 onward after a frame start) pass through as in R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle pulse on the first A1 byte, common to all streams |
| din | input | STREAMS*8 | Transmit bytes, stream s in bits [8s+7:8s] |
| ins_a1_val | input | 8 | Shared replacement for the last A1 byte |
| ins_a2_val | input | 8 | Shared replacement for the first A2 byte |
| ins_frames | input | CNT_W | Shared burst length in frames, 0 = endless |
| ins_enable | input | STREAMS | Per-stream corruption enable |
| dout | output | STREAMS*8 | Bytes with framing inserted, one cycle latency |
| ins_busy | output | STREAMS | Stream is corrupting the current frame |
| ins_done | output | STREAMS | One-cycle pulse when a counted burst completes |

## Verification
The bound checker checks, on every cycle, the invariants that need no scenario. It counts its own byte position from the frame-start pulse. From that count it confirms the fixed A1 and A2 bytes around the two corruptible slots, and that those two slots carry the normal or the programmed value as `ins_busy` dictates. It also confirms that busy moves only after frame starts, that done is a lone pulse at a falling busy, and that outputs are cleared after reset. Only the scoreboard scenarios can show the frame-level sequencing. These cover burst length, endless mode, re-arming through a low enable, mid-frame enable changes being ignored, early abort without done, stream independence, and pass-through in rows past the first.

// File: rtl/sfi_pkg.sv
`timescale 1ns/1ps
package sfi_pkg;

    localparam logic [7:0] A1_PATTERN = 8'hF6;
    localparam logic [7:0] A2_PATTERN = 8'h28;

    // Role of the byte currently at the input.
    typedef enum logic [2:0] {
        SLOT_PAYLOAD,
        SLOT_A1,
        SLOT_A1_LAST,
        SLOT_A2_FIRST,
        SLOT_A2
    } slot_e;

    // Per-stream corruption sequencer.
    typedef enum logic [1:0] {
        BST_IDLE,     // enable was low at the last frame start (or reset)
        BST_COUNTED,  // counted burst in progress
        BST_ENDLESS,  // zero count: corrupt until enable drops
        BST_SPENT     // counted burst over, waiting for enable low
    } burst_state_e;

    typedef struct packed {
        logic busy;
        logic done;
    } burst_stat_t;

    // Classifies a byte position; sts_n is the number of A1 (and A2) bytes.
    function automatic slot_e classify(input logic row_zero,
                                       input int unsigned col,
                                       input int unsigned sts_n);
        slot_e r;
        r = SLOT_PAYLOAD;
        if (row_zero) begin
            if (col < sts_n - 1)            r = SLOT_A1;
            else if (col == sts_n - 1)      r = SLOT_A1_LAST;
            else if (col == sts_n)          r = SLOT_A2_FIRST;
            else if (col < 2 * sts_n)       r = SLOT_A2;
        end
        return r;
    endfunction

endpackage

// File: rtl/sfi_pos_counter.sv
`timescale 1ns/1ps
module sfi_pos_counter
    import sfi_pkg::*;
#(
    parameter int ROW_BYTES = 1080,
    parameter int ROWS      = 9,
    parameter int STS_N     = 12
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  frame_start,
    output slot_e slot
);
    localparam int COL_W = $clog2(ROW_BYTES);
    localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(ROW_BYTES - 1);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

    logic [COL_W-1:0] col_q, col_d;
    logic [ROW_W-1:0] row_q, row_d;
    logic             live_q, live_d;

    // Position of the byte presented in this cycle.
    always_comb begin
        col_d  = '0;
        row_d  = '0;
        live_d = 1'b0;
        if (frame_start) begin
            live_d = 1'b1;
        end else if (live_q) begin
            live_d = 1'b1;
            if (col_q == COL_LAST) begin
                col_d = '0;
                row_d = (row_q == ROW_LAST) ? '0 : row_q + 1'b1;
            end else begin
                col_d = col_q + 1'b1;
                row_d = row_q;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            col_q  <= '0;
            row_q  <= '0;
            live_q <= 1'b0;
        end else begin
            col_q  <= col_d;
            row_q  <= row_d;
            live_q <= live_d;
        end
    end

    assign slot = classify(live_d && (row_d == '0),
                           int'(unsigned'(col_d)),
                           STS_N);

endmodule

// File: rtl/sfi_burst_ctrl.sv
`timescale 1ns/1ps
module sfi_burst_ctrl
    import sfi_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_start,
    input  logic             enable,
    input  logic [CNT_W-1:0] frames_cfg,
    output burst_stat_t      stat
);
    burst_state_e     state_q, state_d;
    logic [CNT_W-1:0] left_q, left_d;
    logic             done_q, done_d;

    always_comb begin
        state_d = state_q;
        left_d  = left_q;
        done_d  = 1'b0;
        if (frame_start) begin
            if (!enable) begin
                state_d = BST_IDLE;
                left_d  = '0;
            end else begin
                unique case (state_q)
                    BST_IDLE: begin
                        if (frames_cfg == '0) begin
                            state_d = BST_ENDLESS;
                        end else begin
                            state_d = BST_COUNTED;
                            left_d  = frames_cfg;
                        end
                    end
                    BST_COUNTED: begin
                        if (left_q == CNT_W'(1)) begin
                            state_d = BST_SPENT;
                            left_d  = '0;
                            done_d  = 1'b1;
                        end else begin
                            left_d = left_q - 1'b1;
                        end
                    end
                    BST_ENDLESS: state_d = BST_ENDLESS;
                    BST_SPENT:   state_d = BST_SPENT;
                    default:     state_d = BST_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= BST_IDLE;
            left_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            left_q  <= left_d;
            done_q  <= done_d;
        end
    end

    assign stat.busy = (state_q == BST_COUNTED) || (state_q == BST_ENDLESS);
    assign stat.done = done_q;

endmodule

// File: rtl/sfi_byte_mux.sv
`timescale 1ns/1ps
module sfi_byte_mux
    import sfi_pkg::*;
(
    input  slot_e       slot,
    input  logic        corrupt,
    input  logic [7:0]  data_in,
    input  logic [7:0]  a1_bad,
    input  logic [7:0]  a2_bad,
    output logic [7:0]  data_out
);
    always_comb begin
        unique case (slot)
            SLOT_A1:       data_out = A1_PATTERN;
            SLOT_A1_LAST:  data_out = corrupt ? a1_bad : A1_PATTERN;
            SLOT_A2_FIRST: data_out = corrupt ? a2_bad : A2_PATTERN;
            SLOT_A2:       data_out = A2_PATTERN;
            default:       data_out = data_in;
        endcase
    end
endmodule

// File: rtl/sfi_frame_inserter.sv
`timescale 1ns/1ps
module sfi_frame_inserter
    import sfi_pkg::*;
#(
    parameter int STREAMS   = 2,
    parameter int ROW_BYTES = 1080,
    parameter int ROWS      = 9,
    parameter int STS_N     = 12,
    parameter int CNT_W     = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 frame_start,
    input  logic [STREAMS*8-1:0] din,
    input  logic [7:0]           ins_a1_val,
    input  logic [7:0]           ins_a2_val,
    input  logic [CNT_W-1:0]     ins_frames,
    input  logic [STREAMS-1:0]   ins_enable,
    output logic [STREAMS*8-1:0] dout,
    output logic [STREAMS-1:0]   ins_busy,
    output logic [STREAMS-1:0]   ins_done
);
    slot_e slot;

    sfi_pos_counter #(
        .ROW_BYTES (ROW_BYTES),
        .ROWS      (ROWS),
        .STS_N     (STS_N)
    ) u_pos (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .slot        (slot)
    );

    for (genvar s = 0; s < STREAMS; s++) begin : g_stream
        burst_stat_t stat;
        logic [7:0]  byte_next;

        sfi_burst_ctrl #(
            .CNT_W (CNT_W)
        ) u_burst (
            .clk         (clk),
            .rst         (rst),
            .frame_start (frame_start),
            .enable      (ins_enable[s]),
            .frames_cfg  (ins_frames),
            .stat        (stat)
        );

        sfi_byte_mux u_mux (
            .slot     (slot),
            .corrupt  (stat.busy),
            .data_in  (din[s*8 +: 8]),
            .a1_bad   (ins_a1_val),
            .a2_bad   (ins_a2_val),
            .data_out (byte_next)
        );

        always_ff @(posedge clk) begin
            if (rst) dout[s*8 +: 8] <= '0;
            else     dout[s*8 +: 8] <= byte_next;
        end

        assign ins_busy[s] = stat.busy;
        assign ins_done[s] = stat.done;
    end

endmodule

// File: rtl/sfi_inserter_checker.sv
`timescale 1ns/1ps
module sfi_inserter_checker
    import sfi_pkg::*;
#(
    parameter int STREAMS = 2,
    parameter int STS_N   = 12
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 frame_start,
    input logic [7:0]           ins_a1_val,
    input logic [7:0]           ins_a2_val,
    input logic [STREAMS*8-1:0] dout,
    input logic [STREAMS-1:0]   ins_busy,
    input logic [STREAMS-1:0]   ins_done
);
    localparam int CW = $clog2(2 * STS_N + 1);
    localparam logic [CW-1:0] SAT = CW'(2 * STS_N);

    // Position of the byte now visible on dout, counted independently.
    logic [CW-1:0] ck_col_q;
    logic          ck_seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ck_col_q  <= '0;
            ck_seen_q <= 1'b0;
        end else if (frame_start) begin
            ck_col_q  <= '0;
            ck_seen_q <= 1'b1;
        end else if (ck_seen_q && ck_col_q < SAT) begin
            ck_col_q  <= ck_col_q + 1'b1;
        end
    end

    assert_outputs_cleared_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (dout == '0 && ins_busy == '0 && ins_done == '0));

    assert_busy_moves_at_fs_R7: assert property (@(posedge clk) disable iff (rst)
        !$past(frame_start) |-> $stable(ins_busy));

    for (genvar g = 0; g < STREAMS; g++) begin : g_chk
        assert_a1_fixed_R2: assert property (@(posedge clk) disable iff (rst)
            (ck_seen_q && ck_col_q < CW'(STS_N - 1)) |-> dout[g*8 +: 8] == A1_PATTERN);

        assert_a2_fixed_R2: assert property (@(posedge clk) disable iff (rst)
            (ck_seen_q && ck_col_q > CW'(STS_N) && ck_col_q < SAT)
            |-> dout[g*8 +: 8] == A2_PATTERN);

        assert_last_a1_slot_R3: assert property (@(posedge clk) disable iff (rst)
            (ck_seen_q && ck_col_q == CW'(STS_N - 1))
            |-> dout[g*8 +: 8] == (ins_busy[g] ? $past(ins_a1_val) : A1_PATTERN));

        assert_first_a2_slot_R3: assert property (@(posedge clk) disable iff (rst)
            (ck_seen_q && ck_col_q == CW'(STS_N))
            |-> dout[g*8 +: 8] == (ins_busy[g] ? $past(ins_a2_val) : A2_PATTERN));

        assert_done_at_busy_fall_R8: assert property (@(posedge clk) disable iff (rst)
            ins_done[g] |-> ($past(ins_busy[g]) && !ins_busy[g]));

        assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
            ins_done[g] |=> !ins_done[g]);
    end

endmodule

bind sfi_frame_inserter sfi_inserter_checker #(
    .STREAMS (STREAMS),
    .STS_N   (STS_N)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .ins_a1_val  (ins_a1_val),
    .ins_a2_val  (ins_a2_val),
    .dout        (dout),
    .ins_busy    (ins_busy),
    .ins_done    (ins_done)
);

// File: tb/sim_sfi_frame_inserter.sv
`timescale 1ns/1ps
module sim_sfi_frame_inserter;
    localparam int STREAMS   = 2;
    localparam int ROW_BYTES = 1080;
    localparam int ROWS      = 9;
    localparam int STS_N     = 12;
    localparam int CNT_W     = 8;
    localparam int FL        = 40;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 frame_start = 1'b0;
    logic [STREAMS*8-1:0] din = '0;
    logic [7:0]           ins_a1_val = 8'h00;
    logic [7:0]           ins_a2_val = 8'h00;
    logic [CNT_W-1:0]     ins_frames = '0;
    logic [STREAMS-1:0]   ins_enable = '0;
    logic [STREAMS*8-1:0] dout;
    logic [STREAMS-1:0]   ins_busy;
    logic [STREAMS-1:0]   ins_done;

    always #2.5 clk = ~clk;

    sfi_frame_inserter #(
        .STREAMS (STREAMS), .ROW_BYTES (ROW_BYTES), .ROWS (ROWS),
        .STS_N (STS_N), .CNT_W (CNT_W)
    ) u0 (
        .clk (clk), .rst (rst), .frame_start (frame_start), .din (din),
        .ins_a1_val (ins_a1_val), .ins_a2_val (ins_a2_val),
        .ins_frames (ins_frames), .ins_enable (ins_enable),
        .dout (dout), .ins_busy (ins_busy), .ins_done (ins_done)
    );

    int checks = 0;
    int errors = 0;
    string scen = "R1";

    logic [STREAMS*8-1:0] q_dout[$];
    logic [2*STREAMS-1:0] q_flags[$];
    string                q_tag[$];

    // Reference model state.
    bit m_live = 0;
    int m_col = 0;
    int m_row = 0;
    int m_st[STREAMS];   // 0 idle, 1 counted, 2 endless, 3 spent
    int m_left[STREAMS];

    initial for (int s = 0; s < STREAMS; s++) begin m_st[s] = 0; m_left[s] = 0; end

    task automatic drive_cycle(input bit fs, input logic [STREAMS-1:0] en);
        logic [STREAMS*8-1:0] d, e;
        logic [STREAMS-1:0]   eb, ed;
        string rq;
        d = (STREAMS*8)'($urandom);
        if (fs) begin m_live = 1; m_col = 0; m_row = 0; end
        else if (m_live) begin
            if (m_col == ROW_BYTES - 1) begin
                m_col = 0;
                m_row = (m_row == ROWS - 1) ? 0 : m_row + 1;
            end else m_col++;
        end
        rq = "R1";
        if (m_live && m_col < 2*STS_N) rq = (m_row == 0) ? "R2" : "R12";
        for (int s = 0; s < STREAMS; s++) begin
            ed[s] = 1'b0;
            if (fs) begin
                if (!en[s]) m_st[s] = 0;
                else if (m_st[s] == 0) begin
                    if (ins_frames == 0) m_st[s] = 2;
                    else begin m_st[s] = 1; m_left[s] = int'(ins_frames); end
                end else if (m_st[s] == 1) begin
                    if (m_left[s] == 1) begin m_st[s] = 3; ed[s] = 1'b1; end
                    else m_left[s]--;
                end
            end
            eb[s] = (m_st[s] == 1) || (m_st[s] == 2);
            e[s*8 +: 8] = d[s*8 +: 8];
            if (m_live && m_row == 0) begin
                if (m_col < STS_N - 1)       e[s*8 +: 8] = 8'hF6;
                else if (m_col == STS_N - 1) e[s*8 +: 8] = eb[s] ? ins_a1_val : 8'hF6;
                else if (m_col == STS_N)     e[s*8 +: 8] = eb[s] ? ins_a2_val : 8'h28;
                else if (m_col < 2*STS_N)    e[s*8 +: 8] = 8'h28;
            end
            if (eb[s] && m_row == 0 && (m_col == STS_N-1 || m_col == STS_N)) rq = "R3";
        end
        frame_start = fs;
        ins_enable  = en;
        din         = d;
        q_dout.push_back(e);
        q_flags.push_back({eb, ed});
        q_tag.push_back({scen, "/", rq});
        @(negedge clk);
    endtask

    // One frame of len bytes; enable switches from en_a to en_b at byte sw.
    task automatic frame(input int len, input logic [STREAMS-1:0] en_a,
                         input int sw, input logic [STREAMS-1:0] en_b);
        for (int i = 0; i < len; i++) drive_cycle(i == 0, (i < sw) ? en_a : en_b);
    endtask

    // Monitor: pops one expected item per cycle, away from the edge.
    always @(posedge clk) begin
        #1;
        if (q_dout.size() > 0) begin
            logic [STREAMS*8-1:0] ex;
            logic [2*STREAMS-1:0] fl;
            string tg;
            ex = q_dout.pop_front();
            fl = q_flags.pop_front();
            tg = q_tag.pop_front();
            checks++;
            if (dout !== ex) begin
                errors++;
                $display("FAIL %s dout actual=%h expected=%h", tg, dout, ex);
            end
            checks++;
            if ({ins_busy, ins_done} !== fl) begin
                errors++;
                $display("FAIL %s/R8 busy,done actual=%b expected=%b", tg, {ins_busy, ins_done}, fl);
            end
        end
    end

    bit finished = 0;
    initial begin
        #750000;
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        din = 16'hA5C3;
        ins_a1_val = 8'h11; ins_a2_val = 8'h22;
        repeat (4) @(negedge clk);
        checks++;   // R10: reset state
        if (dout !== '0 || ins_busy !== '0 || ins_done !== '0) begin
            errors++;
            $display("FAIL R10 reset actual=%h/%b/%b expected=0/0/0", dout, ins_busy, ins_done);
        end
        rst = 1'b0;

        scen = "R1";  repeat (10) drive_cycle(0, 2'b00);       // no frame yet
        scen = "R2";  frame(FL, 2'b00, FL, 2'b00); frame(FL, 2'b00, FL, 2'b00);
        // Counted burst of 3 on stream 0 only; stream 1 untouched (R9).
        ins_frames = 8'd3;
        scen = "R4";  repeat (5) frame(FL, 2'b01, FL, 2'b01);
        scen = "R6";  repeat (2) frame(FL, 2'b01, FL, 2'b01);  // held high: no restart
        ins_frames = 8'd2;
        frame(FL, 2'b00, FL, 2'b00);                           // low seen at frame start
        repeat (3) frame(FL, 2'b01, FL, 2'b01);                // re-armed: 2 frames
        // Endless mode on stream 1 with changed shared values.
        ins_frames = 8'd0; ins_a1_val = 8'h5A; ins_a2_val = 8'hC4;
        scen = "R5";  repeat (4) frame(FL, 2'b10, FL, 2'b10);
        frame(FL, 2'b00, FL, 2'b00);                           // stops
        // Mid-frame enable changes are ignored until a frame start.
        ins_frames = 8'd1;
        scen = "R7";  frame(FL, 2'b00, 5, 2'b11);
        frame(FL, 2'b11, 6, 2'b00);
        frame(FL, 2'b00, FL, 2'b00);
        // Abort of a counted burst without done.
        ins_frames = 8'd5; ins_a1_val = 8'hFF; ins_a2_val = 8'h00;
        scen = "R11"; frame(FL, 2'b11, FL, 2'b11); frame(FL, 2'b11, FL, 2'b11);
        frame(FL, 2'b00, FL, 2'b00);
        scen = "R9";  ins_frames = 8'd2;
        frame(FL, 2'b01, FL, 2'b01); frame(FL, 2'b11, FL, 2'b11); frame(FL, 2'b11, FL, 2'b11);
        // Long frame: row 1 start passes through, corruption active.
        scen = "R12"; ins_frames = 8'd0;
        frame(FL, 2'b00, FL, 2'b00);
        frame(ROW_BYTES + 40, 2'b11, ROW_BYTES + 40, 2'b11);
        frame(FL, 2'b00, FL, 2'b00);
        drive_cycle(0, 2'b00);
        repeat (3) @(negedge clk);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule